// File: doc/BRIEF.md
# Array Integrity Signature Engine

This block reads every word of a memory array in a fixed address order and compresses the words that belong to chosen sectors into a 160-bit multiple-input signature register (MISR). Software loads a seed into the signature and raises the enable input. When the done flag appears, software compares the signature with a golden value stored outside the tested sectors. An ECC error reported on any read raises a sticky flag, including reads from sectors that are not accumulated. While the walk runs, a busy output keeps ordinary bus traffic away from the array.

Two address orders are offered. The sequential order counts upward. The alternating order pairs each lower-half address with its bitwise complement, so that consecutive reads toggle every address line. Dropping the enable before completion aborts the walk, and the signature keeps its partial value. A fresh seed must be written before the engine will start again. One sector index is reserved as a shadow area and is never accumulated, whatever its mask bit says.

Top module: `arr_sig_checker`

## Requirements
- R1: After reset, busy, done, ecc_flag and rd_en are 0 and the signature is all zeros.
- R2: A seed_wr pulse while busy and done are low loads seed_data into the signature on the next edge. A seed_wr pulse while busy is high has no effect on the final signature.
- R3: With run_en high and a seed written since the last start, busy and rd_en go high on the next edge. Without such a seed, run_en does not start a walk.
- R4: With seq_mode=1 latched at start, rd_addr steps 0, 1, ..., 2^ADDR_W-1 with one read per cycle.
- R5: With seq_mode=0 latched at start, rd_addr visits k, then ~k (ADDR_W bits), for k = 0 .. 2^(ADDR_W-1)-1 in ascending order.
- R6: rd_data and ecc_err belong to the rd_addr issued one cycle earlier. For a read from a selected sector, the signature S becomes ((S<<1) ^ (S[159] ? T : 0)) ^ {128'b0, rd_data}, where T has bits 159, 142, 141 and 0 set. The sector index is the top SECT_W bits of the address, and sector s is selected when sect_mask[s] is 1. Reads from unselected sectors leave S unchanged.
- R7: The sector with index SHADOW_IDX (default 3) is never accumulated, even if its mask bit is 1.
- R8: ecc_flag is cleared at start and set by ecc_err on any read of the walk, whether or not the sector is selected.
- R9: After the data of the last address is absorbed, done rises and busy falls. done stays high while run_en stays high, and it clears on the edge after run_en goes low.
- R10: Driving run_en low while busy drops busy and rd_en on the next edge. The signature then holds its partial value and done stays low.
- R11: busy is high from the first issued read until the last read data is absorbed, and rd_en is never high without busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enable: high starts or continues a walk, low aborts or acknowledges |
| seq_mode | input | 1 | Address order: 1 sequential, 0 complement-pair |
| sect_mask | input | 2^SECT_W | Sector select mask |
| seed_wr | input | 1 | Load seed_data into the signature |
| seed_data | input | 160 | Seed value, word k in bits 32k+31:32k |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 32 | Array read data, one cycle after rd_en |
| ecc_err | input | 1 | ECC error for the returned read |
| busy | output | 1 | Walk in progress; normal accesses must be held off |
| done | output | 1 | Walk complete |
| ecc_flag | output | 1 | ECC error seen during the walk |
| signature | output | 160 | MISR value |

## Verification
A corrupted address counter or order bit shows up on rd_addr within one cycle of the fault, because every issued address is compared against the expected order. A wrong sector decision, a mistimed data capture or a bad feedback tap is folded into the signature and only surfaces when done rises, so whole walks are compared against a reference model. A faulty state or arming flag appears within a cycle on busy, done or rd_en, and the abort, hold and refusal sequences are built to expose it.

// File: rtl/asc_pkg.sv
package asc_pkg;
    localparam int WORD_W     = 32;
    localparam int MISR_WORDS = 5;
    localparam int MISR_W     = WORD_W * MISR_WORDS;

    // Galois feedback mask: x^160 + x^159 + x^142 + x^141 + 1
    localparam logic [MISR_W-1:0] MISR_TAPS =
        (MISR_W'(1) << 159) | (MISR_W'(1) << 142) | (MISR_W'(1) << 141) | MISR_W'(1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } walk_st_e;
endpackage

// File: rtl/asc_addr_gen.sv
module asc_addr_gen #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic              seq_mode,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = {1'b0, idx[ADDR_W-1:1]};
        if (seq_mode) begin
            addr = idx;
        end else begin
            addr = idx[0] ? ~base : base;
        end
    end
endmodule

// File: rtl/asc_sect_filter.sv
module asc_sect_filter #(
    parameter int ADDR_W     = 6,
    parameter int SECT_W     = 2,
    parameter int SHADOW_IDX = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [(1<<SECT_W)-1:0] mask,
    output logic                   sel
);
    localparam int NSECT = 1 << SECT_W;

    logic [NSECT-1:0] allow;

    for (genvar g = 0; g < NSECT; g++) begin : g_allow
        if (g == SHADOW_IDX) begin : g_shadow
            assign allow[g] = 1'b0;
        end else begin : g_normal
            assign allow[g] = mask[g];
        end
    end

    assign sel = allow[addr[ADDR_W-1 -: SECT_W]];
endmodule

// File: rtl/asc_misr_step.sv
module asc_misr_step
    import asc_pkg::*;
(
    input  logic [MISR_W-1:0] cur,
    input  logic [WORD_W-1:0] data,
    output logic [MISR_W-1:0] nxt
);
    logic [MISR_W-1:0] shifted;

    always_comb begin
        shifted = {cur[MISR_W-2:0], 1'b0};
        if (cur[MISR_W-1]) begin
            shifted = shifted ^ MISR_TAPS;
        end
        nxt = shifted ^ {{(MISR_W-WORD_W){1'b0}}, data};
    end
endmodule

// File: rtl/arr_sig_checker.sv
module arr_sig_checker
    import asc_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int SECT_W     = 2,
    parameter int SHADOW_IDX = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic                   seq_mode,
    input  logic [(1<<SECT_W)-1:0] sect_mask,
    input  logic                   seed_wr,
    input  logic [MISR_W-1:0]      seed_data,
    output logic                   rd_en,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic [WORD_W-1:0]      rd_data,
    input  logic                   ecc_err,
    output logic                   busy,
    output logic                   done,
    output logic                   ecc_flag,
    output logic [MISR_W-1:0]      signature
);
    localparam int IDX_W = ADDR_W + 1;

    typedef struct packed {
        walk_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic              mode;
        logic              armed;
        logic              vld;
        logic              sel;
        logic              ecc;
        logic [MISR_W-1:0] misr;
    } walk_t;

    walk_t q, d;

    logic [ADDR_W-1:0] addr;
    logic              sel_now;
    logic              issue;
    logic [MISR_W-1:0] misr_nxt;

    asc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .idx      (q.idx[ADDR_W-1:0]),
        .seq_mode (q.mode),
        .addr     (addr)
    );

    asc_sect_filter #(
        .ADDR_W     (ADDR_W),
        .SECT_W     (SECT_W),
        .SHADOW_IDX (SHADOW_IDX)
    ) u_filt (
        .addr (addr),
        .mask (sect_mask),
        .sel  (sel_now)
    );

    asc_misr_step u_misr (
        .cur  (q.misr),
        .data (rd_data),
        .nxt  (misr_nxt)
    );

    assign issue = (q.st == ST_RUN) && !q.idx[ADDR_W];

    always_comb begin
        d     = q;
        d.vld = issue;
        d.sel = sel_now;
        unique case (q.st)
            ST_IDLE: begin
                if (seed_wr) begin
                    d.misr  = seed_data;
                    d.armed = 1'b1;
                end
                if (run_en && q.armed) begin
                    d.st    = ST_RUN;
                    d.idx   = '0;
                    d.mode  = seq_mode;
                    d.armed = 1'b0;
                    d.ecc   = 1'b0;
                end
            end
            ST_RUN: begin
                if (!run_en) begin
                    d.st  = ST_IDLE;
                    d.vld = 1'b0;
                end else begin
                    if (issue) begin
                        d.idx = q.idx + 1'b1;
                    end
                    if (q.vld) begin
                        if (q.sel) begin
                            d.misr = misr_nxt;
                        end
                        if (ecc_err) begin
                            d.ecc = 1'b1;
                        end
                        if (q.idx[ADDR_W]) begin
                            d.st = ST_DONE;
                        end
                    end
                end
            end
            ST_DONE: begin
                if (!run_en) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.idx   <= '0;
            q.mode  <= 1'b1;
            q.armed <= 1'b0;
            q.vld   <= 1'b0;
            q.sel   <= 1'b0;
            q.ecc   <= 1'b0;
            q.misr  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_en     = issue;
    assign rd_addr   = addr;
    assign busy      = (q.st == ST_RUN);
    assign done      = (q.st == ST_DONE);
    assign ecc_flag  = q.ecc;
    assign signature = q.misr;
endmodule

// File: rtl/asc_checker.sv
module asc_checker
    import asc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              seed_wr,
    input logic [MISR_W-1:0] seed_data,
    input logic              rd_en,
    input logic              busy,
    input logic              done,
    input logic [MISR_W-1:0] signature
);
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !run_en) |=> !done);

    p_rd_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run_en) |=> (!busy && !rd_en && !done));

    p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && seed_wr) |=> (signature == $past(seed_data)));

    p_sig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !seed_wr) |=> $stable(signature));
endmodule

bind arr_sig_checker asc_checker u_asc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .seed_wr   (seed_wr),
    .seed_data (seed_data),
    .rd_en     (rd_en),
    .busy      (busy),
    .done      (done),
    .signature (signature)
);

// File: tb/tb_arr_sig_checker.sv
module tb_arr_sig_checker;
    import asc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int SW         = 2;
    localparam int SH         = 3;
    localparam int DEPTH      = 1 << AW;
    localparam int NS         = 1 << SW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              seq_mode = 1'b1;
    logic [NS-1:0]     sect_mask = '0;
    logic              seed_wr = 1'b0;
    logic [MISR_W-1:0] seed_data = '0;
    logic [WORD_W-1:0] rd_data = '0;
    logic              ecc_err = 1'b0;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic              busy, done, ecc_flag;
    logic [MISR_W-1:0] signature;
    logic [DEPTH-1:0]  ecc_bad = '0;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0]   addr_q[$];
    logic [MISR_W:0] sig_q[$];
    string           cur_tag = "R4";
    logic            done_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arr_sig_checker #(.ADDR_W(AW), .SECT_W(SW), .SHADOW_IDX(SH)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .seq_mode(seq_mode),
        .sect_mask(sect_mask), .seed_wr(seed_wr), .seed_data(seed_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ecc_err(ecc_err),
        .busy(busy), .done(done), .ecc_flag(ecc_flag), .signature(signature)
    );

    function automatic logic [WORD_W-1:0] word_at(int a);
        return 32'hA5C3_0F1E ^ (32'(a) * 32'h0101_0003) ^ (32'(a) << 24);
    endfunction

    // array model: registered read, data one cycle after the strobe
    always @(posedge clk) begin
        rd_data <= word_at(int'(rd_addr));
        ecc_err <= rd_en && ecc_bad[rd_addr];
    end

    function automatic logic [AW-1:0] addr_of(int i, bit m);
        logic [AW-1:0] base;
        if (m) return AW'(i);
        base = AW'(i >> 1);
        return (i % 2 == 1) ? ~base : base;
    endfunction

    function automatic bit is_sel(int a, logic [NS-1:0] m);
        int s;
        s = a >> (AW - SW);
        return (s != SH) && m[s];
    endfunction

    function automatic logic [MISR_W-1:0] step(logic [MISR_W-1:0] s, logic [WORD_W-1:0] w);
        logic [MISR_W-1:0] t;
        logic [MISR_W-1:0] r;
        t = '0;
        t[159] = 1'b1; t[142] = 1'b1; t[141] = 1'b1; t[0] = 1'b1;
        r = {s[MISR_W-2:0], 1'b0};
        if (s[MISR_W-1]) r = r ^ t;
        return r ^ {{(MISR_W-WORD_W){1'b0}}, w};
    endfunction

    task automatic cmp(string req, string what, logic [MISR_W:0] act, logic [MISR_W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // scoreboard driver side: model the whole walk
    task automatic push_expect(logic [MISR_W-1:0] seed, bit m, logic [NS-1:0] msk);
        logic [MISR_W-1:0] s;
        logic e;
        s = seed;
        e = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [AW-1:0] a;
            a = addr_of(i, m);
            addr_q.push_back(a);
            if (is_sel(int'(a), msk)) s = step(s, word_at(int'(a)));
            if (ecc_bad[a]) e = 1'b1;
        end
        sig_q.push_back({e, s});
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (addr_q.size() == 0) begin
                cmp(cur_tag, "unexpected read", {1'b0, 154'b0, rd_addr}, '0);
            end else begin
                logic [AW-1:0] ea;
                ea = addr_q.pop_front();
                cmp(cur_tag, "rd_addr", {155'b0, rd_addr}, {155'b0, ea});
            end
        end
        if (rst_n && done && !done_prev) begin
            if (sig_q.size() == 0) begin
                cmp("R9", "done without walk", 1, 0);
            end else begin
                logic [MISR_W:0] ex;
                ex = sig_q.pop_front();
                cmp({"R6 ", cur_tag}, "signature", {1'b0, signature}, {1'b0, ex[MISR_W-1:0]});
                cmp("R8", "ecc_flag", {160'b0, ecc_flag}, {160'b0, ex[MISR_W]});
                cmp("R9", "busy at done", {160'b0, busy}, 0);
            end
        end
        done_prev = done;
    end

    task automatic seed_load(logic [MISR_W-1:0] v);
        seed_data = v;
        seed_wr   = 1'b1;
        tick();
        seed_wr   = 1'b0;
        cmp("R2", "seed load", {1'b0, signature}, {1'b0, v});
    endtask

    task automatic full_run(logic [MISR_W-1:0] seed, bit m, logic [NS-1:0] msk, string tag);
        seq_mode  = m;
        sect_mask = msk;
        cur_tag   = tag;
        seed_load(seed);
        push_expect(seed, m, msk);
        run_en = 1'b1;
        tick();
        cmp("R11", "busy after start", {160'b0, busy}, 1);
        cmp("R3", "rd_en after start", {160'b0, rd_en}, 1);
        // seed write during the walk must not disturb the result (R2)
        seed_data = ~seed;
        seed_wr   = 1'b1;
        tick();
        seed_wr   = 1'b0;
        while (!done) tick();
        tick();
        tick();
        cmp("R9", "done held", {160'b0, done}, 1);
        run_en = 1'b0;
        tick();
        cmp("R9", "done cleared", {160'b0, done}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [MISR_W-1:0] snap;
        repeat (3) tick();
        cmp("R1", "busy", {160'b0, busy}, 0);
        cmp("R1", "done", {160'b0, done}, 0);
        cmp("R1", "ecc_flag", {160'b0, ecc_flag}, 0);
        cmp("R1", "rd_en", {160'b0, rd_en}, 0);
        cmp("R1", "signature", {1'b0, signature}, 0);
        rst_n = 1'b1;
        tick();

        full_run({5{32'h1357_9BDF}}, 1'b1, 4'b0011, "R4");

        ecc_bad[60] = 1'b1;   // shadow sector: never accumulated, still flagged
        full_run({32'hDEAD_BEEF, 128'h0123_4567_89AB_CDEF_0F0F_F0F0_5555_AAAA}, 1'b0, 4'b1111, "R5");

        ecc_bad = '0;         // only the shadow bit set: signature stays at seed
        full_run({160{1'b1}}, 1'b1, 4'b1000, "R7");

        ecc_bad[5] = 1'b1;    // error in an unselected sector
        full_run({5{32'h8000_0001}}, 1'b0, 4'b0100, "R8");
        ecc_bad = '0;

        // abort with partial signature, then refusal without a new seed
        seq_mode  = 1'b1;
        sect_mask = 4'b1111;
        cur_tag   = "R10";
        seed_load({5{32'h0F1E_2D3C}});
        for (int i = 0; i < DEPTH; i++) addr_q.push_back(AW'(i));
        run_en = 1'b1;
        repeat (12) tick();
        snap   = signature;
        run_en = 1'b0;
        tick();
        cmp("R10", "busy after abort", {160'b0, busy}, 0);
        cmp("R10", "rd_en after abort", {160'b0, rd_en}, 0);
        repeat (4) tick();
        cmp("R10", "partial signature held", {1'b0, signature}, {1'b0, snap});
        cmp("R10", "done after abort", {160'b0, done}, 0);
        addr_q.delete();
        run_en = 1'b1;
        repeat (4) tick();
        cmp("R3", "no start without seed", {160'b0, busy}, 0);
        run_en = 1'b0;
        tick();

        full_run({5{32'h2468_ACE0}}, 1'b1, 4'b0110, "R4");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule